// File: doc/BRIEF.md
# Graphics Command Packet Framer

The framer sits between a word-wide command stream and the drawing engine of a graphics pipeline. It accepts 32-bit words on a valid/ready input and groups them into complete command packets. The opcode in the top byte of each packet's first word sets the packet's length. For most drawing opcodes that length is a fixed count. For polyline opcodes the packet ends at a marker word.

The framer stores a packet until its last word has arrived and then plays it out as one burst on the output port. The packet's opcode and word count stay on the output for the whole burst. The first word of any packet may be one of several other kinds, and none of these appear on the packet output:

- **Image-transfer and copy headers** are collected in full and reported on their own one-cycle strobe, together with their argument words.
- **Settings words** are written into an eight-entry register bank. Two fields of that bank are mirrored onto a status output.
- **The interrupt opcode** produces a one-cycle pulse.
- **Unknown opcodes** are dropped.

Top module: `gpu_pkt_framer`

## Requirements
- R1: The opcode is bits 31:24 of a packet's first word. Packet lengths in words, including the opcode word, are: 0x02 → 3; 0x20–0x23 → 4; 0x24–0x27 → 7; 0x28–0x2B → 5; 0x2C–0x2F → 9; 0x30–0x33 → 6; 0x34–0x37 → 9; 0x38–0x3B → 8; 0x3C–0x3F → 12.
- R2: More packet lengths: 0x40–0x47 → 3; 0x50–0x57 → 4; 0x60–0x63 → 3; 0x64–0x67 → 4; 0x68–0x6B → 2; 0x70–0x73 → 2; 0x74–0x77 → 3; 0x78–0x7B → 2; 0x7C–0x7F → 3.
- R3: A flat polyline (0x48–0x4F) ends at the first word whose index is 3 or more and whose value ANDed with 0xF000F000 equals 0x50005000. That marker word is the last word of the packet. A matching word at index 1 or 2 does not end the packet.
- R4: A shaded polyline (0x58–0x5F) tests for the marker only at even indices of 4 or more. A matching word at an odd index does not end the packet.
- R5: A polyline that reaches DEPTH words without a marker is closed at DEPTH words.
- R6: A packet is played out as consecutive `out_valid` cycles, starting with the opcode word. `out_last` marks the final word. `out_op` and `out_count` hold the opcode and word count for the whole burst. `in_ready` stays low while any word other than the last is being presented.
- R7: Opcodes 0xA0–0xBF (write header) and 0xC0–0xDF (read header) take 3 words. Opcodes 0x80–0x9F (copy header) take 4 words. When a header is complete, `xfer_valid` pulses for one cycle with:
  - `xfer_kind` set to 1 for write, 2 for read and 3 for copy;
  - `xfer_op` set to the opcode;
  - `xfer_arg0`, `xfer_arg1` and `xfer_arg2` set to words 1, 2 and 3 (`xfer_arg2` is 0 for write and read headers).

  No packet is output for a header.
- R8: An opcode 0xE0–0xE7 is a one-word setting. The whole word is stored into bank entry (opcode & 7) and no packet is output. Writes to entries other than 1 and 6 leave `status` unchanged.
- R9: `status[10:0]` equals bits 10:0 of bank entry 1, and `status[12:11]` equals bits 1:0 of bank entry 6. Both update one cycle after the setting word is accepted.
- R10: Opcode 0x1F is a one-word packet. It raises `irq_pulse` for exactly one cycle, in the cycle after it is accepted, and no packet is output.
- R11: Every other opcode (0x00, 0x01, 0x03–0x1E, 0x6C–0x6F, 0xE8–0xFF) is dropped as a one-word no-op. The next word is decoded as a new opcode.
- R12: A packet is not output until all of its words have arrived. Pauses in `in_valid` between its words do not affect the packet.
- R13: Reset discards a partly collected packet and sets bank entry i to (0xE0+i)<<24. After reset, `status` is 0, `in_ready` is 1, and `out_valid`, `xfer_valid` and `irq_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is valid |
| in_data | input | 32 | Input command word |
| in_ready | output | 1 | Framer can accept a word |
| out_valid | output | 1 | Packet word valid |
| out_data | output | 32 | Packet word |
| out_last | output | 1 | Final word of the packet |
| out_op | output | 8 | Opcode of the packet being played out |
| out_count | output | $clog2(DEPTH)+1 | Word count of the packet being played out |
| xfer_valid | output | 1 | One-cycle strobe: transfer or copy header complete |
| xfer_kind | output | 2 | 1 write, 2 read, 3 copy |
| xfer_op | output | 8 | Header opcode |
| xfer_arg0 | output | 32 | Header word 1 |
| xfer_arg1 | output | 32 | Header word 2 |
| xfer_arg2 | output | 32 | Header word 3 (copy only, else 0) |
| irq_pulse | output | 1 | Interrupt opcode seen |
| status | output | 13 | Mirrored settings fields |

## Verification
The hardest cases to reach from the ports are polyline marker words at the wrong positions: a matching word at index 2 of a flat polyline, or at an odd index of a shaded polyline. The framer must not close the packet on either. The stimulus places these decoys deliberately and checks the exact word count of the packet that comes out. A second case is a polyline with no marker at all, which is driven to the storage limit to show the forced close and a clean next packet. A reset issued in the middle of a twelve-word packet is followed by a short packet, which shows that no stale words leak into it.

// File: rtl/framer_pkg.sv
package framer_pkg;

  typedef enum logic [3:0] {
    K_DROP, K_IRQ, K_SET, K_FIXED, K_FLAT, K_SHADE, K_WRITE, K_READ, K_COPY
  } kind_t;

  // words after the opcode word for fixed-length drawing packets
  function automatic logic [3:0] fixed_extra(input logic [7:0] op);
    logic [3:0] n;
    if (op == 8'h02) n = 4'd2;
    else begin
      case (op[7:2])
        6'h08: n = 4'd3;
        6'h09: n = 4'd6;
        6'h0A: n = 4'd4;
        6'h0B: n = 4'd8;
        6'h0C: n = 4'd5;
        6'h0D: n = 4'd8;
        6'h0E: n = 4'd7;
        6'h0F: n = 4'd11;
        6'h10, 6'h11: n = 4'd2;
        6'h14, 6'h15: n = 4'd3;
        6'h18: n = 4'd2;
        6'h19: n = 4'd3;
        6'h1A: n = 4'd1;
        6'h1C: n = 4'd1;
        6'h1D: n = 4'd2;
        6'h1E: n = 4'd1;
        6'h1F: n = 4'd2;
        default: n = 4'd0;
      endcase
    end
    return n;
  endfunction

endpackage

// File: rtl/framer_decode.sv
module framer_decode
  import framer_pkg::*;
(
  input  logic [7:0] op,
  output kind_t      kind,
  output logic [4:0] total
);
  logic [3:0] extra;

  always_comb begin
    extra = fixed_extra(op);
    total = 5'd0;
    if (op == 8'h1F)                      kind = K_IRQ;
    else if (op[7:3] == 5'b11100)         kind = K_SET;
    else if (op[7:3] == 5'b01001)         kind = K_FLAT;
    else if (op[7:3] == 5'b01011)         kind = K_SHADE;
    else if (op[7:5] == 3'b100) begin     kind = K_COPY;  total = 5'd4; end
    else if (op[7:5] == 3'b101) begin     kind = K_WRITE; total = 5'd3; end
    else if (op[7:5] == 3'b110) begin     kind = K_READ;  total = 5'd3; end
    else if (extra != 4'd0) begin         kind = K_FIXED; total = {1'b0, extra} + 5'd1; end
    else                                  kind = K_DROP;
  end
endmodule

// File: rtl/framer_store.sv
module framer_store #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/framer_settings.sv
module framer_settings #(
  parameter int NREG = 8,
  localparam int SW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic [31:0]   wr_data,
  output logic [12:0]   stat
);
  logic [31:0] bank [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                              bank[i] <= (32'hE0 + 32'(i)) << 24;
      else if (wr_en && wr_sel == SW'(i))   bank[i] <= wr_data;
    end
  end

  assign stat = {bank[6][1:0], bank[1][10:0]};

  // R8: without a write the mirrored fields stay put
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(stat));
endmodule

// File: rtl/gpu_pkt_framer.sv
module gpu_pkt_framer
  import framer_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [31:0]   in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [31:0]   out_data,
  output logic          out_last,
  output logic [7:0]    out_op,
  output logic [CW-1:0] out_count,
  output logic          xfer_valid,
  output logic [1:0]    xfer_kind,
  output logic [7:0]    xfer_op,
  output logic [31:0]   xfer_arg0,
  output logic [31:0]   xfer_arg1,
  output logic [31:0]   xfer_arg2,
  output logic          irq_pulse,
  output logic [12:0]   status
);
  typedef enum logic {S_COLL, S_EMIT} state_t;

  state_t        state;
  kind_t         kind_r, dec_kind;
  logic [4:0]    need_r, dec_total;
  logic [AW-1:0] idx, rd_ptr;
  logic [CW-1:0] idx_p1;
  logic [7:0]    hdr_op;
  logic          acc, term, cap, done, is_xfer, set_we;

  framer_decode u_dec (.op(in_data[31:24]), .kind(dec_kind), .total(dec_total));

  framer_store #(.DEPTH(DEPTH), .WIDTH(32)) u_store (
    .clk(clk), .we(acc), .waddr(idx), .wdata(in_data),
    .raddr(rd_ptr), .rdata(out_data));

  assign set_we = acc && idx == '0 && dec_kind == K_SET;

  framer_settings #(.NREG(8)) u_set (
    .clk(clk), .rst(rst), .wr_en(set_we), .wr_sel(in_data[26:24]),
    .wr_data(in_data), .stat(status));

  assign in_ready = (state == S_COLL);
  assign acc      = in_valid && in_ready;

  always_comb begin
    term    = (in_data & 32'hF000_F000) == 32'h5000_5000;
    idx_p1  = {1'b0, idx} + CW'(1);
    cap     = idx == AW'(DEPTH - 1);
    is_xfer = (kind_r == K_WRITE) || (kind_r == K_READ) || (kind_r == K_COPY);
    case (kind_r)
      K_FLAT:  done = (term && idx >= AW'(3)) || cap;
      K_SHADE: done = (term && idx >= AW'(4) && !idx[0]) || cap;
      default: done = idx_p1 == CW'(need_r);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_COLL;
      idx        <= '0;
      rd_ptr     <= '0;
      kind_r     <= K_DROP;
      need_r     <= '0;
      hdr_op     <= '0;
      out_valid  <= 1'b0;
      out_last   <= 1'b0;
      out_op     <= '0;
      out_count  <= '0;
      xfer_valid <= 1'b0;
      xfer_kind  <= '0;
      xfer_op    <= '0;
      xfer_arg0  <= '0;
      xfer_arg1  <= '0;
      xfer_arg2  <= '0;
      irq_pulse  <= 1'b0;
    end else begin
      xfer_valid <= 1'b0;
      irq_pulse  <= 1'b0;
      case (state)
        S_COLL: begin
          out_valid <= 1'b0;
          out_last  <= 1'b0;
          if (acc) begin
            if (idx == '0) begin
              case (dec_kind)
                K_IRQ:  irq_pulse <= 1'b1;
                K_SET, K_DROP: ;
                default: begin
                  kind_r    <= dec_kind;
                  need_r    <= dec_total;
                  hdr_op    <= in_data[31:24];
                  idx       <= AW'(1);
                  xfer_arg0 <= '0;
                  xfer_arg1 <= '0;
                  xfer_arg2 <= '0;
                end
              endcase
            end else begin
              if (is_xfer) begin
                if (idx == AW'(1)) xfer_arg0 <= in_data;
                if (idx == AW'(2)) xfer_arg1 <= in_data;
                if (idx == AW'(3)) xfer_arg2 <= in_data;
              end
              if (done) begin
                idx <= '0;
                if (is_xfer) begin
                  xfer_valid <= 1'b1;
                  xfer_op    <= hdr_op;
                  xfer_kind  <= (kind_r == K_WRITE) ? 2'd1 :
                                (kind_r == K_READ)  ? 2'd2 : 2'd3;
                end else begin
                  state     <= S_EMIT;
                  out_op    <= hdr_op;
                  out_count <= idx_p1;
                  rd_ptr    <= '0;
                end
              end else begin
                idx <= idx + AW'(1);
              end
            end
          end
        end
        S_EMIT: begin
          out_valid <= 1'b1;
          rd_ptr    <= rd_ptr + AW'(1);
          if ({1'b0, rd_ptr} == out_count - CW'(1)) begin
            out_last <= 1'b1;
            state    <= S_COLL;
          end else begin
            out_last <= 1'b0;
          end
        end
        default: state <= S_COLL;
      endcase
    end
  end

  // R6: input held off while non-final words are presented
  p_ready_emit_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_last |-> !in_ready);
  // R6: a burst ends with a gap
  p_gap_after_last_r6: assert property (@(posedge clk) disable iff (rst)
    out_last |=> !out_valid);
  // R5: emitted count stays within storage
  p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_count != '0 && out_count <= CW'(DEPTH)));
  // R7: header strobe lasts one cycle
  p_xfer_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    xfer_valid |=> !xfer_valid);
  // R10: interrupt opcode yields a pulse next cycle
  p_irq_r10: assert property (@(posedge clk) disable iff (rst)
    (acc && idx == '0 && in_data[31:24] == 8'h1F) |=> irq_pulse);
  // R9: status follows a setting-1 write
  p_status_r9: assert property (@(posedge clk) disable iff (rst)
    (acc && idx == '0 && in_data[31:24] == 8'hE1) |=> status[10:0] == $past(in_data[10:0]));
endmodule

// File: tb/tb_gpu_pkt_framer.sv
module tb_gpu_pkt_framer;
  localparam int DEPTH = 64;
  localparam int CW = $clog2(DEPTH) + 1;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic in_ready, out_valid, out_last, xfer_valid, irq_pulse;
  logic [31:0] out_data, xfer_arg0, xfer_arg1, xfer_arg2;
  logic [7:0] out_op, xfer_op;
  logic [CW-1:0] out_count;
  logic [1:0] xfer_kind;
  logic [12:0] status;

  always #4 clk = ~clk;

  gpu_pkt_framer #(.DEPTH(DEPTH)) dut (.*);

  int total = 0, bad = 0;
  int pk_n = 0, cur_n = 0, last_n = 0, last_cnt = 0, ready_viol = 0, x_n = 0, irq_n = 0;
  logic [7:0] last_op;
  logic [31:0] cur [0:79];
  logic [31:0] lastw [0:79];
  logic [31:0] sbuf [0:79];
  int sn = 0;
  logic [1:0] x_kind;
  logic [7:0] x_op;
  logic [31:0] x_a0, x_a1, x_a2;

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (!out_last && in_ready) ready_viol++;
        if (cur_n < 80) cur[cur_n] = out_data;
        cur_n++;
        if (out_last) begin
          for (int i = 0; i < 80; i++) lastw[i] = cur[i];
          last_n = cur_n; last_op = out_op; last_cnt = int'(out_count);
          cur_n = 0; pk_n++;
        end
      end
      if (xfer_valid) begin
        x_n++; x_kind = xfer_kind; x_op = xfer_op;
        x_a0 = xfer_arg0; x_a1 = xfer_arg1; x_a2 = xfer_arg2;
      end
      if (irq_pulse) irq_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] w);
    in_valid = 1'b1; in_data = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic push(input logic [31:0] w);
    sbuf[sn] = w; sn++;
    send(w);
  endtask

  function automatic int exp_words(input logic [7:0] op);
    if (op == 8'h02) return 3;
    if (op >= 8'h20 && op <= 8'h23) return 4;
    if (op >= 8'h24 && op <= 8'h27) return 7;
    if (op >= 8'h28 && op <= 8'h2B) return 5;
    if (op >= 8'h2C && op <= 8'h2F) return 9;
    if (op >= 8'h30 && op <= 8'h33) return 6;
    if (op >= 8'h34 && op <= 8'h37) return 9;
    if (op >= 8'h38 && op <= 8'h3B) return 8;
    if (op >= 8'h3C && op <= 8'h3F) return 12;
    if (op >= 8'h40 && op <= 8'h47) return 3;
    if (op >= 8'h50 && op <= 8'h57) return 4;
    if (op >= 8'h60 && op <= 8'h63) return 3;
    if (op >= 8'h64 && op <= 8'h67) return 4;
    if (op >= 8'h68 && op <= 8'h6B) return 2;
    if (op >= 8'h70 && op <= 8'h73) return 2;
    if (op >= 8'h74 && op <= 8'h77) return 3;
    if (op >= 8'h78 && op <= 8'h7B) return 2;
    if (op >= 8'h7C && op <= 8'h7F) return 3;
    return 0;
  endfunction

  // compare last emitted packet against sbuf[0..n-1]
  task automatic chk_pkt(input string req, input int pk_before, input int n);
    int mism = 0;
    chk(pk_n == pk_before + 1, req, pk_n - pk_before, 1);
    chk(last_n == n && last_cnt == n, req, last_n, n);
    chk(last_op == sbuf[0][31:24], req, last_op, sbuf[0][31:24]);
    for (int i = 0; i < n && i < 80; i++) if (lastw[i] !== sbuf[i]) mism++;
    chk(mism == 0, req, mism, 0);
  endtask

  task automatic t_fixed(input logic [7:0] op, input string req);
    int p0 = pk_n;
    int n = exp_words(op);
    sn = 0;
    push({op, 24'h13579B});
    for (int i = 1; i < n; i++) push({8'(i), op, 16'h0F0F ^ 16'(i * 77)});
    idle(n + 6);
    chk_pkt(req, p0, n);
  endtask

  task automatic t_reset;
    chk(status == 13'd0, "R13 status", status, 0);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R13 ready/valid", {in_ready, out_valid}, 2'b10);
    chk(xfer_valid == 1'b0 && irq_pulse == 1'b0, "R13 strobes", {xfer_valid, irq_pulse}, 0);
  endtask

  task automatic t_partial;
    int p0 = pk_n;
    sn = 0;
    push(32'h2800_0001); push(32'h0000_0002);
    idle(25);
    chk(pk_n == p0, "R12 held", pk_n - p0, 0);
    push(32'h0000_0003); idle(5);
    push(32'h0000_0004); push(32'h0000_0005);
    idle(10);
    chk_pkt("R12 completed", p0, 5);
  endtask

  task automatic t_flat;
    int p0 = pk_n;
    sn = 0;
    push(32'h4800_00FF);
    push(32'h0001_0001);
    push(32'h5000_5000);            // index 2: too early to close
    push(32'h0003_0003);
    push(32'h5ABC_5123);            // index 4: closes
    idle(10);
    chk_pkt("R3 flat polyline", p0, 5);
  endtask

  task automatic t_shade;
    int p0 = pk_n;
    sn = 0;
    push(32'h5A00_0011);
    push(32'h0000_0001); push(32'h0000_0002); push(32'h0000_0003);
    push(32'h0000_0004);
    push(32'h5555_5555);            // index 5: odd, ignored
    push(32'h5000_5FFF);            // index 6: closes
    idle(12);
    chk_pkt("R4 shaded polyline", p0, 7);
  endtask

  task automatic t_cap;
    int p0 = pk_n;
    sn = 0;
    push(32'h4C00_0000);
    for (int i = 1; i < DEPTH; i++) push(32'h0000_1111 + i);
    idle(DEPTH + 6);
    chk_pkt("R5 capped polyline", p0, DEPTH);
    t_fixed(8'h02, "R5 after cap");
  endtask

  task automatic t_xfer;
    int p0 = pk_n;
    int x0 = x_n;
    send(32'hA000_0000); send(32'h0010_0020); send(32'h0040_0008);
    idle(3);
    chk(x_n == x0 + 1 && x_kind == 2'd1, "R7 write kind", x_kind, 1);
    chk(x_op == 8'hA0 && x_a0 == 32'h0010_0020 && x_a1 == 32'h0040_0008 && x_a2 == 0,
        "R7 write args", x_a1, 32'h0040_0008);
    send(32'hC500_0000); send(32'h0001_0002); send(32'h0003_0004);
    idle(3);
    chk(x_n == x0 + 2 && x_kind == 2'd2 && x_op == 8'hC5, "R7 read kind", x_kind, 2);
    send(32'h8000_0000); send(32'h0000_0010); send(32'h0020_0030); send(32'h0008_0008);
    idle(3);
    chk(x_n == x0 + 3 && x_kind == 2'd3, "R7 copy kind", x_kind, 3);
    chk(x_a0 == 32'h10 && x_a1 == 32'h0020_0030 && x_a2 == 32'h0008_0008, "R7 copy args", x_a2, 32'h0008_0008);
    chk(pk_n == p0, "R7 no packet", pk_n - p0, 0);
  endtask

  task automatic t_settings;
    int p0 = pk_n;
    send(32'hE100_07FF); idle(2);
    chk(status[10:0] == 11'h7FF, "R9 low field", status[10:0], 11'h7FF);
    send(32'hE600_0002); idle(2);
    chk(status[12:11] == 2'd2, "R9 high field", status[12:11], 2);
    send(32'hE3FF_FFFF); idle(2);
    chk(status == {2'd2, 11'h7FF}, "R8 other entry no effect", status, {2'd2, 11'h7FF});
    send(32'hE100_0123); idle(2);
    chk(status[10:0] == 11'h123, "R8 overwrite", status[10:0], 11'h123);
    chk(pk_n == p0, "R8 no packet", pk_n - p0, 0);
  endtask

  task automatic t_irq;
    int p0 = pk_n;
    int i0 = irq_n;
    send(32'h1F00_0000); idle(3);
    chk(irq_n == i0 + 1, "R10 single pulse", irq_n - i0, 1);
    chk(pk_n == p0, "R10 no packet", pk_n - p0, 0);
  endtask

  task automatic t_drop;
    int p0 = pk_n;
    send(32'h0000_0000); send(32'h0500_0000); send(32'h6C00_0000);
    send(32'h1E00_0000); send(32'hF000_0000);
    idle(4);
    chk(pk_n == p0 && x_n >= 0, "R11 dropped", pk_n - p0, 0);
    t_fixed(8'h40, "R11 next decoded");
  endtask

  task automatic t_reset_mid;
    int p0;
    send(32'hE100_0055); idle(2);
    send(32'h3C00_0000); send(32'h0000_0001); send(32'h0000_0002);
    @(negedge clk); rst = 1'b1; idle(2); rst = 1'b0; idle(1);
    chk(status == 13'd0, "R13 bank reinit", status, 0);
    p0 = pk_n;
    sn = 0;
    push(32'h0200_0000); push(32'h0001_0001); push(32'h0002_0002);
    idle(8);
    chk_pkt("R13 partial discarded", p0, 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_fixed(8'h02, "R1 fill");
    t_fixed(8'h21, "R1 grp20");
    t_fixed(8'h26, "R1 grp24");
    t_fixed(8'h2B, "R1 grp28");
    t_fixed(8'h2C, "R1 grp2C");
    t_fixed(8'h31, "R1 grp30");
    t_fixed(8'h36, "R1 grp34");
    t_fixed(8'h38, "R1 grp38");
    t_fixed(8'h3F, "R1 grp3C");
    t_fixed(8'h45, "R2 grp40");
    t_fixed(8'h52, "R2 grp50");
    t_fixed(8'h60, "R2 grp60");
    t_fixed(8'h65, "R2 grp64");
    t_fixed(8'h6A, "R2 grp68");
    t_fixed(8'h70, "R2 grp70");
    t_fixed(8'h77, "R2 grp74");
    t_fixed(8'h78, "R2 grp78");
    t_fixed(8'h7D, "R2 grp7C");
    t_partial();
    t_flat();
    t_shade();
    t_cap();
    t_xfer();
    t_settings();
    t_irq();
    t_drop();
    t_reset_mid();
    chk(ready_viol == 0, "R6 ready low in burst", ready_viol, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule